// File: doc/BRIEF.md
# Write-Back Set-Associative Data Cache

This block is a byte-addressed data cache whose shape is fixed at build time by three exponents: log2 of the data capacity in bytes, log2 of the block size in bytes, and log2 of the number of ways in a set. A zero way exponent gives a direct-mapped cache. A way exponent equal to the capacity exponent minus the block exponent gives a single fully associative set. A client issues one single-byte read or write at a time over a valid/ready handshake. Each access gets back a response pulse with a hit flag and a data byte.

Misses go to a lower-level memory over a block-wide request/acknowledge port. Stores use write-allocate and write-back. A write miss first brings the block in, then merges the byte and marks the block dirty. A dirty block leaves the cache only when it is evicted, and then the whole block is written out before the refill read starts. Replacement inside a set uses true least-recently-used order. Free-running counters record reads, writes, the hit/miss split of each, and write-backs.

Top module: `wb_cache`

## Requirements
- R1: An address splits into three fields. The low BLK_LOG bits are the byte offset. The next CAP_LOG-BLK_LOG-WAY_LOG bits are the set index. All remaining upper bits are the tag. Addresses that differ only in the tag compete for the ways of one set.
- R2: `reqReady` is high when the cache is idle. It is low from the cycle after a request is accepted until that request's response, so only one access is ever in flight.
- R3: A hit raises `respValid` with `respHit`=1 at the second rising edge after the accepting edge. A hit makes no memory transaction.
- R4: `respRdata` is the current value of the addressed byte: the most recently written value, or the lower memory's value if the byte was never written. For a write, `respRdata` is the byte just written.
- R5: On a miss the victim is an invalid way if one exists. Otherwise it is the least recently used way. Both hits and fills make the touched way the most recently used.
- R6: A write miss fills the block, then writes the byte into it and marks the block dirty. Its response carries `respHit`=0.
- R7: Evicting a valid dirty block first performs one write transaction with `memWrite`=1. `memAddr` is the victim block's base address, and `memWdata` carries the whole block, with byte k at bits 8k+7:8k. The refill read starts only after that transaction. `cntWritebacks` increments once.
- R8: Evicting a clean block, or filling an invalid way, makes no write transaction and leaves `cntWritebacks` unchanged.
- R9: After reset all blocks are invalid and every counter is zero. `reqReady` is 1, and `respValid` and `memReq` are 0.
- R10: Each response increments exactly one of `cntReads`/`cntWrites`, and exactly one of the matching hit/miss counters. The increment happens at the edge that raises `respValid`. No counter moves at any other time, apart from the write-back counter.
- R11: `memReq`, `memWrite` and `memAddr` are held stable until `memAck` is sampled high. A refill read addresses the requested block's base address, and the block returns on `memRdata` with byte k at bits 8k+7:8k.
- R12: A miss response appears at the rising edge right after the edge that samples the refill acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Client request present |
| reqReady | output | 1 | Cache can accept a request |
| reqWrite | input | 1 | 1 = byte write, 0 = byte read |
| reqAddr | input | ADDR_W | Byte address |
| reqWdata | input | 8 | Byte to write |
| respValid | output | 1 | One-cycle response pulse |
| respHit | output | 1 | 1 if the access hit |
| respRdata | output | 8 | Current value of the addressed byte |
| memReq | output | 1 | Lower memory transaction request |
| memWrite | output | 1 | 1 = write-back, 0 = refill read |
| memAddr | output | ADDR_W | Block-aligned memory address |
| memWdata | output | 8<<BLK_LOG | Victim block data |
| memAck | input | 1 | Lower memory completes the transaction |
| memRdata | input | 8<<BLK_LOG | Refill block data |
| cntReads | output | CNT_W | Reads completed |
| cntWrites | output | CNT_W | Writes completed |
| cntReadHits | output | CNT_W | Read hits |
| cntReadMisses | output | CNT_W | Read misses |
| cntWriteHits | output | CNT_W | Write hits |
| cntWriteMisses | output | CNT_W | Write misses |
| cntWritebacks | output | CNT_W | Dirty blocks written back |

## Verification
A hit's response is due exactly two rising edges after acceptance. A miss's response is due one edge after the refill acknowledge, so its timing depends on when the bench's memory model answers. The counters change on the same edge as `respValid`. The bench therefore drives and samples on falling edges, counts falling edges from acceptance, and demands a count of exactly two for every access its behavioural model predicts to hit. Write-back address and data are checked inside the memory model at the moment it acknowledges, against the model's predicted victim. Hit flag, data and all counters are compared at the falling edge where the response is visible.

// File: rtl/wb_cache_pkg.sv
package wb_cache_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_WBACK,
    ST_FILL
  } cache_state_e;

  // strobes from control to datapath and statistics
  typedef struct packed {
    logic latchReq;    // capture the accepted request
    logic commitHit;   // hit: update recency, merge write byte
    logic commitFill;  // refill arrived: install block
    logic selWb;       // memory address selects the victim block
    logic countWb;     // a write-back completed
  } cache_strobe_t;

endpackage

// File: rtl/wb_cache_ctrl.sv
module wb_cache_ctrl
  import wb_cache_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  input  logic          lookHit,
  input  logic          victimDirty,
  input  logic          memAck,
  output logic          reqReady,
  output logic          memReq,
  output logic          memWrite,
  output cache_strobe_t strobe
);

  cache_state_e st, stNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) st <= ST_IDLE;
    else       st <= stNext;
  end

  always_comb begin
    stNext = st;
    unique case (st)
      ST_IDLE:   if (reqValid) stNext = ST_LOOKUP;
      ST_LOOKUP: begin
        if (lookHit)          stNext = ST_IDLE;
        else if (victimDirty) stNext = ST_WBACK;
        else                  stNext = ST_FILL;
      end
      ST_WBACK:  if (memAck) stNext = ST_FILL;
      ST_FILL:   if (memAck) stNext = ST_IDLE;
      default:   stNext = ST_IDLE;
    endcase
  end

  assign reqReady = (st == ST_IDLE);
  assign memReq   = (st == ST_WBACK) || (st == ST_FILL);
  assign memWrite = (st == ST_WBACK);

  always_comb begin
    strobe            = '0;
    strobe.latchReq   = (st == ST_IDLE) && reqValid;
    strobe.commitHit  = (st == ST_LOOKUP) && lookHit;
    strobe.commitFill = (st == ST_FILL) && memAck;
    strobe.selWb      = (st == ST_WBACK);
    strobe.countWb    = (st == ST_WBACK) && memAck;
  end

  // R2: once accepted, no second request may be taken
  assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  // R7: a finished write-back is followed directly by the refill read
  assert_wb_then_fill_R7: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWrite && memAck) |=> (memReq && !memWrite));

  // R11: request and direction held until acknowledged
  assert_mem_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memWrite)));

endmodule

// File: rtl/wb_cache_datapath.sv
module wb_cache_datapath
  import wb_cache_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int CAP_LOG = 8,
  parameter int BLK_LOG = 2,
  parameter int WAY_LOG = 1,
  localparam int BLK_BITS = 8 << BLK_LOG
) (
  input  logic                clk,
  input  logic                rstN,
  input  cache_strobe_t       strobe,
  input  logic                reqWrite,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [7:0]          reqWdata,
  input  logic [BLK_BITS-1:0] memRdata,
  output logic                lookHit,
  output logic                victimDirty,
  output logic                isWrite,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [BLK_BITS-1:0] memWdata,
  output logic                respValid,
  output logic                respHit,
  output logic [7:0]          respRdata
);

  localparam int SET_BITS  = CAP_LOG - BLK_LOG - WAY_LOG;
  localparam int SETS      = 1 << SET_BITS;
  localparam int WAYS      = 1 << WAY_LOG;
  localparam int BLK_BYTES = 1 << BLK_LOG;
  localparam int TAG_W     = ADDR_W - BLK_LOG - SET_BITS;
  localparam int IDX_W     = (SET_BITS > 0) ? SET_BITS : 1;
  localparam int WAY_W     = (WAY_LOG > 0) ? WAY_LOG : 1;
  localparam int OFF_W     = (BLK_LOG > 0) ? BLK_LOG : 1;

  // captured request
  logic [ADDR_W-1:0] addrQ;
  logic              writeQ;
  logic [7:0]        wdataQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      writeQ <= 1'b0;
      wdataQ <= '0;
    end else if (strobe.latchReq) begin
      addrQ  <= reqAddr;
      writeQ <= reqWrite;
      wdataQ <= reqWdata;
    end
  end

  logic [IDX_W-1:0] setIdx;
  logic [TAG_W-1:0] tagQ;
  logic [OFF_W-1:0] offQ;
  logic [OFF_W+2:0] bitPos;

  assign setIdx = IDX_W'((addrQ >> BLK_LOG) & ADDR_W'(SETS - 1));
  assign tagQ   = TAG_W'(addrQ >> (BLK_LOG + SET_BITS));
  assign offQ   = OFF_W'(addrQ & ADDR_W'(BLK_BYTES - 1));
  assign bitPos = {offQ, 3'b000};
  assign isWrite = writeQ;

  // storage
  logic [TAG_W-1:0]    tagArr   [SETS][WAYS];
  logic [BLK_BITS-1:0] dataArr  [SETS][WAYS];
  logic                validArr [SETS][WAYS];
  logic                dirtyArr [SETS][WAYS];
  logic [WAY_W-1:0]    ageArr   [SETS][WAYS];

  // lookup
  logic [WAYS-1:0] hitVec;
  logic [WAY_W-1:0] hitWay, lruWay, invWay, vicWay, touchWay;
  logic             anyInvalid;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hitVec[w] = validArr[setIdx][w] && (tagArr[setIdx][w] == tagQ);
  end

  assign lookHit = |hitVec;

  always_comb begin
    hitWay     = '0;
    lruWay     = '0;
    invWay     = '0;
    anyInvalid = 1'b0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hitVec[w]) hitWay = WAY_W'(w);
      if (ageArr[setIdx][w] == WAY_W'(WAYS - 1)) lruWay = WAY_W'(w);
      if (!validArr[setIdx][w]) begin
        invWay     = WAY_W'(w);
        anyInvalid = 1'b1;
      end
    end
  end

  assign vicWay      = anyInvalid ? invWay : lruWay;
  assign victimDirty = validArr[setIdx][vicWay] && dirtyArr[setIdx][vicWay];
  assign touchWay    = strobe.commitFill ? vicWay : hitWay;

  // line merge
  logic [BLK_BITS-1:0] newLine;
  logic [WAY_W-1:0]    touchAge;
  logic                touch;

  assign touch    = strobe.commitHit || strobe.commitFill;
  assign touchAge = ageArr[setIdx][touchWay];

  always_comb begin
    newLine = strobe.commitFill ? memRdata : dataArr[setIdx][touchWay];
    if (writeQ) newLine[bitPos +: 8] = wdataQ;
  end

  // memory port data
  logic [ADDR_W-1:0] victimBase, fillBase;
  assign victimBase = (ADDR_W'(tagArr[setIdx][vicWay]) << (BLK_LOG + SET_BITS))
                    | (ADDR_W'(setIdx) << BLK_LOG);
  assign fillBase   = addrQ & ~ADDR_W'(BLK_BYTES - 1);
  assign memAddr    = strobe.selWb ? victimBase : fillBase;
  assign memWdata   = dataArr[setIdx][vicWay];

  // state bits with reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          validArr[s][w] <= 1'b0;
          dirtyArr[s][w] <= 1'b0;
          ageArr[s][w]   <= WAY_W'(w);
        end
      end
    end else begin
      if (strobe.commitFill) begin
        validArr[setIdx][vicWay] <= 1'b1;
        dirtyArr[setIdx][vicWay] <= writeQ;
      end else if (strobe.commitHit && writeQ) begin
        dirtyArr[setIdx][hitWay] <= 1'b1;
      end
      if (touch) begin
        for (int w = 0; w < WAYS; w++) begin
          if (WAY_W'(w) == touchWay)
            ageArr[setIdx][w] <= '0;
          else if (ageArr[setIdx][w] < touchAge)
            ageArr[setIdx][w] <= ageArr[setIdx][w] + 1'b1;
        end
      end
    end
  end

  // tag and data, no reset needed
  always_ff @(posedge clk) begin
    if (strobe.commitFill) tagArr[setIdx][vicWay] <= tagQ;
    if (touch) dataArr[setIdx][touchWay] <= newLine;
  end

  // response
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respValid <= 1'b0;
      respHit   <= 1'b0;
      respRdata <= '0;
    end else begin
      respValid <= touch;
      respHit   <= strobe.commitHit;
      if (touch) respRdata <= newLine[bitPos +: 8];
    end
  end

  // R5: a fill never lands on a valid way while an invalid one exists
  assert_fill_prefers_invalid_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commitFill && anyInvalid) |-> !validArr[setIdx][vicWay]);

endmodule

// File: rtl/wb_cache_stats.sv
module wb_cache_stats #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             respond,
  input  logic             wasHit,
  input  logic             isWrite,
  input  logic             countWb,
  output logic [CNT_W-1:0] cntReads,
  output logic [CNT_W-1:0] cntWrites,
  output logic [CNT_W-1:0] cntReadHits,
  output logic [CNT_W-1:0] cntReadMisses,
  output logic [CNT_W-1:0] cntWriteHits,
  output logic [CNT_W-1:0] cntWriteMisses,
  output logic [CNT_W-1:0] cntWritebacks
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntReads       <= '0;
      cntWrites      <= '0;
      cntReadHits    <= '0;
      cntReadMisses  <= '0;
      cntWriteHits   <= '0;
      cntWriteMisses <= '0;
      cntWritebacks  <= '0;
    end else begin
      if (respond) begin
        if (isWrite) begin
          cntWrites <= cntWrites + 1'b1;
          if (wasHit) cntWriteHits   <= cntWriteHits + 1'b1;
          else        cntWriteMisses <= cntWriteMisses + 1'b1;
        end else begin
          cntReads <= cntReads + 1'b1;
          if (wasHit) cntReadHits   <= cntReadHits + 1'b1;
          else        cntReadMisses <= cntReadMisses + 1'b1;
        end
      end
      if (countWb) cntWritebacks <= cntWritebacks + 1'b1;
    end
  end

endmodule

// File: rtl/wb_cache.sv
module wb_cache
  import wb_cache_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int CAP_LOG = 8,
  parameter int BLK_LOG = 2,
  parameter int WAY_LOG = 1,
  parameter int CNT_W   = 32,
  localparam int BLK_BITS = 8 << BLK_LOG
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic                reqWrite,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [7:0]          reqWdata,
  output logic                respValid,
  output logic                respHit,
  output logic [7:0]          respRdata,
  output logic                memReq,
  output logic                memWrite,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [BLK_BITS-1:0] memWdata,
  input  logic                memAck,
  input  logic [BLK_BITS-1:0] memRdata,
  output logic [CNT_W-1:0]    cntReads,
  output logic [CNT_W-1:0]    cntWrites,
  output logic [CNT_W-1:0]    cntReadHits,
  output logic [CNT_W-1:0]    cntReadMisses,
  output logic [CNT_W-1:0]    cntWriteHits,
  output logic [CNT_W-1:0]    cntWriteMisses,
  output logic [CNT_W-1:0]    cntWritebacks
);

  cache_strobe_t strobe;
  logic lookHit, victimDirty, isWrite;

  wb_cache_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .lookHit     (lookHit),
    .victimDirty (victimDirty),
    .memAck      (memAck),
    .reqReady    (reqReady),
    .memReq      (memReq),
    .memWrite    (memWrite),
    .strobe      (strobe)
  );

  wb_cache_datapath #(
    .ADDR_W  (ADDR_W),
    .CAP_LOG (CAP_LOG),
    .BLK_LOG (BLK_LOG),
    .WAY_LOG (WAY_LOG)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .reqWrite    (reqWrite),
    .reqAddr     (reqAddr),
    .reqWdata    (reqWdata),
    .memRdata    (memRdata),
    .lookHit     (lookHit),
    .victimDirty (victimDirty),
    .isWrite     (isWrite),
    .memAddr     (memAddr),
    .memWdata    (memWdata),
    .respValid   (respValid),
    .respHit     (respHit),
    .respRdata   (respRdata)
  );

  wb_cache_stats #(.CNT_W(CNT_W)) u_stats (
    .clk            (clk),
    .rstN           (rstN),
    .respond        (strobe.commitHit || strobe.commitFill),
    .wasHit         (strobe.commitHit),
    .isWrite        (isWrite),
    .countWb        (strobe.countWb),
    .cntReads       (cntReads),
    .cntWrites      (cntWrites),
    .cntReadHits    (cntReadHits),
    .cntReadMisses  (cntReadMisses),
    .cntWriteHits   (cntWriteHits),
    .cntWriteMisses (cntWriteMisses),
    .cntWritebacks  (cntWritebacks)
  );

  logic [CNT_W-1:0] doneCount;
  assign doneCount = cntReads + cntWrites;

  // R3: two edges after acceptance either a response or a memory request
  assert_hit_or_miss_due_R3: assert property (@(posedge clk) disable iff (!rstN)
    $past(reqValid && reqReady, 2) |-> (respValid || memReq));

  // R10: access counters step by one exactly with each response
  assert_count_step_R10: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> (doneCount == $past(doneCount) + CNT_W'(1)));

  assert_count_still_R10: assert property (@(posedge clk) disable iff (!rstN)
    !respValid |-> $stable(doneCount));

  // R12: a miss response follows the refill acknowledge
  assert_miss_after_fill_R12: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && !respHit) |-> $past(memReq && memAck && !memWrite));

  // R11: memory address held while waiting
  assert_mem_addr_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> $stable(memAddr));

endmodule

// File: tb/wb_cache_test.sv
module wb_cache_test;

  localparam int ADDR_W    = 16;
  localparam int CAP_LOG   = 8;
  localparam int BLK_LOG   = 2;
  localparam int WAY_LOG   = 1;
  localparam int CNT_W     = 32;
  localparam int SET_BITS  = CAP_LOG - BLK_LOG - WAY_LOG;
  localparam int SETS      = 1 << SET_BITS;
  localparam int WAYS      = 1 << WAY_LOG;
  localparam int BLK_BYTES = 1 << BLK_LOG;
  localparam int BLK_BITS  = 8 * BLK_BYTES;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [7:0] reqWdata = '0;
  logic reqReady, respValid, respHit;
  logic [7:0] respRdata;
  logic memReq, memWrite;
  logic [ADDR_W-1:0] memAddr;
  logic [BLK_BITS-1:0] memWdata;
  logic memAck = 1'b0;
  logic [BLK_BITS-1:0] memRdata = '0;
  logic [CNT_W-1:0] cntReads, cntWrites, cntReadHits, cntReadMisses;
  logic [CNT_W-1:0] cntWriteHits, cntWriteMisses, cntWritebacks;

  always #5 clk = ~clk;

  wb_cache #(
    .ADDR_W(ADDR_W), .CAP_LOG(CAP_LOG), .BLK_LOG(BLK_LOG),
    .WAY_LOG(WAY_LOG), .CNT_W(CNT_W)
  ) uut (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata),
    .respValid(respValid), .respHit(respHit), .respRdata(respRdata),
    .memReq(memReq), .memWrite(memWrite), .memAddr(memAddr),
    .memWdata(memWdata), .memAck(memAck), .memRdata(memRdata),
    .cntReads(cntReads), .cntWrites(cntWrites),
    .cntReadHits(cntReadHits), .cntReadMisses(cntReadMisses),
    .cntWriteHits(cntWriteHits), .cntWriteMisses(cntWriteMisses),
    .cntWritebacks(cntWritebacks)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference state
  logic [7:0] mainMem [0:65535];
  logic [7:0] refMem  [0:65535];
  int lruList [SETS][$];
  bit refDirty [int];
  int eReads = 0, eWrites = 0, eRH = 0, eRM = 0, eWH = 0, eWM = 0, eWb = 0;
  bit expWbPending = 0;
  int expWbAddr = 0;
  int expFillAddr = 0;
  int memLat = 1;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // lower memory model, acts on falling edges
  initial begin
    int waitCnt = 0;
    forever begin
      @(negedge clk);
      if (memAck) begin
        memAck = 1'b0;
        waitCnt = 0;
      end else if (memReq) begin
        waitCnt++;
        if (waitCnt >= memLat) begin
          if (memWrite) begin
            logic [BLK_BITS-1:0] expData;
            for (int k = 0; k < BLK_BYTES; k++)
              expData[8*k +: 8] = refMem[int'(memAddr) + k];
            check(expWbPending, "R8 unexpected write-back", 1, 0);
            check(int'(memAddr) == expWbAddr, "R7 write-back address", memAddr, expWbAddr);
            check(memWdata == expData, "R7 write-back data", memWdata, expData);
            for (int k = 0; k < BLK_BYTES; k++)
              mainMem[int'(memAddr) + k] = memWdata[8*k +: 8];
            expWbPending = 0;
          end else begin
            check(!expWbPending, "R7 refill before write-back", 0, 1);
            check(int'(memAddr) == expFillAddr, "R1 R11 refill address", memAddr, expFillAddr);
            for (int k = 0; k < BLK_BYTES; k++)
              memRdata[8*k +: 8] = mainMem[int'(memAddr) + k];
          end
          memAck = 1'b1;
          memLat = 1 + $urandom_range(0, 2);
        end
      end
    end
  end

  task automatic checkCounters();
    check(cntReads == CNT_W'(eReads), "R10 reads", cntReads, eReads);
    check(cntWrites == CNT_W'(eWrites), "R10 writes", cntWrites, eWrites);
    check(cntReadHits == CNT_W'(eRH), "R10 read hits", cntReadHits, eRH);
    check(cntReadMisses == CNT_W'(eRM), "R10 read misses", cntReadMisses, eRM);
    check(cntWriteHits == CNT_W'(eWH), "R10 write hits", cntWriteHits, eWH);
    check(cntWriteMisses == CNT_W'(eWM), "R10 write misses", cntWriteMisses, eWM);
    check(cntWritebacks == CNT_W'(eWb), "R7 R8 write-backs", cntWritebacks, eWb);
  endtask

  task automatic doAccess(input bit wr, input int a, input logic [7:0] d);
    int setI = (a >> BLK_LOG) % SETS;
    int tag  = a >> (BLK_LOG + SET_BITS);
    int blk  = a >> BLK_LOG;
    int pos  = -1;
    bit expHit;
    logic [7:0] expData;
    int n;
    for (int i = 0; i < lruList[setI].size(); i++)
      if (lruList[setI][i] == tag) pos = i;
    expHit = (pos >= 0);
    expFillAddr = blk << BLK_LOG;
    if (expHit) begin
      lruList[setI].delete(pos);
    end else if (lruList[setI].size() == WAYS) begin
      int vt = lruList[setI].pop_back();
      int vb = (vt << SET_BITS) | setI;
      if (refDirty.exists(vb)) begin
        expWbPending = 1;
        expWbAddr = (vb << BLK_LOG) & ((1 << ADDR_W) - 1);
        refDirty.delete(vb);
        eWb++;
      end
    end
    lruList[setI].push_front(tag);
    if (wr) refDirty[blk] = 1;
    if (wr) begin eWrites++; if (expHit) eWH++; else eWM++; end
    else    begin eReads++;  if (expHit) eRH++; else eRM++; end
    expData = wr ? d : refMem[a];

    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = ADDR_W'(a); reqWdata = d;
    check(reqReady, "R2 ready when idle", reqReady, 1);
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    n = 1;
    check(!reqReady, "R2 busy after accept", reqReady, 0);
    while (!respValid && n < 100) begin
      @(negedge clk);
      n++;
    end
    check(respValid, "R3 R12 response arrives", respValid, 1);
    check(respHit == expHit, "R3 R5 R6 R12 hit flag", respHit, expHit);
    if (expHit) check(n == 2, "R3 hit latency", n, 2);
    check(respRdata == expData, "R4 data byte", respRdata, expData);
    checkCounters();
    if (wr) refMem[a] = d;
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 65536; i++) begin
      mainMem[i] = 8'(i) ^ 8'(i >> 8) ^ 8'h5A;
      refMem[i]  = mainMem[i];
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: state held in reset
    check(!respValid, "R9 respValid in reset", respValid, 0);
    check(!memReq, "R9 memReq in reset", memReq, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady, "R9 ready after reset", reqReady, 1);
    checkCounters();

    // R9 cold miss, then hits in the same block
    doAccess(0, 'h0010, 8'h00);
    doAccess(0, 'h0010, 8'h00);
    doAccess(0, 'h0013, 8'h00);
    // R4 write hit then read back
    doAccess(1, 'h0011, 8'hA7);
    doAccess(0, 'h0011, 8'h00);
    // R5 LRU in set 0 (stride 128 bytes shares a set), R8 clean evictions
    doAccess(0, 'h0000, 8'h00);
    doAccess(0, 'h0080, 8'h00);
    doAccess(0, 'h0000, 8'h00);
    doAccess(0, 'h0100, 8'h00);
    doAccess(0, 'h0000, 8'h00);
    doAccess(0, 'h0080, 8'h00);
    // R6 write misses allocate and dirty, R7 dirty eviction
    doAccess(1, 'h0004, 8'h11);
    doAccess(1, 'h0086, 8'h22);
    doAccess(0, 'h0104, 8'h00);
    doAccess(0, 'h0004, 8'h00);
    doAccess(0, 'h0086, 8'h00);
    // R1 same set, different tags far apart
    doAccess(1, 'h8008, 8'h33);
    doAccess(0, 'h4008, 8'h00);
    doAccess(0, 'h0008, 8'h00);
    doAccess(0, 'h8008, 8'h00);

    // mixed stream
    for (int i = 0; i < 2000; i++) begin
      int a = (i % 7 == 0) ? int'($urandom_range(0, 255)) : int'($urandom_range(0, 1023));
      bit wr = ($urandom_range(0, 9) < 4);
      doAccess(wr, a, 8'($urandom));
    end

    repeat (4) @(negedge clk);
    checkCounters();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule